// File: doc/BRIEF.md
# Streaming Byte-Permute and Checksum Stage

This stage sits in a 32-bit word stream between a source and a sink. Every word it accepts is reshaped: its four byte lanes are reordered in one of four ways, and the bit order within each byte can then be flipped. The reshaped word leaves through a registered output one cycle later. In the same cycle the reshaped word is folded into a running checksum. The checksum can be one of three CRCs or the 16-bit ones'-complement Internet sum, or it can be switched off.

A transfer is a run of words ending with a word whose `in_last` flag is set. The function word `cfg_func` and the `cfg_restart` control are sampled only when the first word of a transfer is accepted. They then hold until that transfer closes. If `cfg_restart` is high at that moment, the accumulator is loaded with the seed of the selected checksum before the first word is folded in. If it is low, the sum carries on from the previous transfer. Once the closing word is accepted, `csum_out` holds the result of the whole transfer.

A small two-state controller tracks the transfer framing. In `ST_IDLE` the stage waits between transfers. The transition *open* (a first word is accepted without `in_last`) moves it to `ST_BUSY`. A single-word transfer, or a cycle with no accepted word, leaves it in `ST_IDLE`. The transition *close* (a word is accepted with `in_last`) returns it from `ST_BUSY` to `ST_IDLE`. In `ST_BUSY` a cycle with no accepted word keeps it in `ST_BUSY`.

Top module: `word_reshape_sum`

## Requirements
- R1: The lane order is chosen by `cfg_func[17:16]`. Output byte k (byte 0 in bits 7:0) is taken from the following input byte: 0 passes byte k through, 3 takes byte 3-k (full reversal), 2 takes byte k^2 (the 16-bit halves are exchanged), and 1 takes byte k^1 (the bytes inside each half are exchanged).
- R2: When `cfg_func[19]` is 1, the bit order inside each byte is reversed after the lane reordering. When it is 0, the bits are left as they are.
- R3: When `cfg_func[31:30]` is 2'b11, `cfg_func[22:20]` selects the checksum. Code 1 is a CRC-16 with polynomial 0x8005 and seed 0. Code 2 is a CRC-CCITT with polynomial 0x1021 and seed 0xFFFF. Code 3 is a CRC-32 with polynomial 0x04C11DB7 and seed 0xFFFFFFFF. Each CRC shifts the word in most significant bit first, without reflection and without a final XOR. The 16-bit results are zero-extended in `csum_out`.
- R4: Code 4 adds the two 16-bit halves of the word to the 16-bit sum, seed 0, and folds the end-around carries back in. The result is not complemented.
- R5: Any other code, or `cfg_func[31:30]` not equal to 2'b11, disables the checksum: accepted words leave `csum_out` unchanged.
- R6: If `cfg_restart` is 1 when a transfer's first word is accepted, the accumulator takes the seed of the selected checksum before that word is folded in. With the checksum disabled the seed is 0.
- R7: If `cfg_restart` is 0 at a transfer's first word, the accumulation continues from the value left by the previous transfer.
- R8: `in_ready` is high whenever the output register is empty or `out_ready` is high. Each accepted word appears on `out_data`/`out_last` in the cycle after acceptance. A word held under backpressure stays stable until it is taken. No word is lost or duplicated.
- R9: `cfg_func` and `cfg_restart` are sampled only at the first word of a transfer. Changes made while a transfer is open have no effect until the word with `in_last` has been accepted.
- R10: After reset `out_valid` is 0, `in_ready` is 1 and `csum_out` is 0.
- R11: The checksum is computed over the word after lane reordering and bit reversal. `csum_out` shows the updated value in the cycle after each accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_func | input | 32 | Function word: lane order, bit reversal, checksum kind |
| cfg_restart | input | 1 | Reseed the checksum at the start of the next transfer |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Stage can take a word |
| in_data | input | 32 | Input word |
| in_last | input | 1 | Input word closes the transfer |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Sink takes the word |
| out_data | output | 32 | Reshaped word |
| out_last | output | 1 | Reshaped word closes the transfer |
| csum_out | output | 32 | Running checksum |

## Verification
The hardest case to reach is a function word that changes while a transfer is open and the output is stalled. In that case the latched setting must keep governing both the reshaping and the sum. The stimulus scrambles `cfg_func` and `cfg_restart` right after each first word is accepted, under random output stalls. A bench model that uses only the sampled value then checks every later word and the closing checksum. Continuation without restart is a second awkward case, above all when the checksum kind changes between transfers. It is reached by chaining transfers with random restart choices, so that each sum depends on the whole earlier history.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

    localparam int SUM_W = 32;

    localparam logic [31:0] CRC32_POLY = 32'h04C11DB7;
    localparam logic [15:0] CRC16_POLY = 16'h8005;
    localparam logic [15:0] CCITT_POLY = 16'h1021;

    typedef enum logic [1:0] {
        LANE_KEEP     = 2'd0,
        LANE_HALFBYTE = 2'd1,
        LANE_HALFSWAP = 2'd2,
        LANE_FULLREV  = 2'd3
    } lane_mode_e;

    typedef enum logic [2:0] {
        SUM_OFF   = 3'd0,
        SUM_CRC16 = 3'd1,
        SUM_CCITT = 3'd2,
        SUM_CRC32 = 3'd3,
        SUM_INET  = 3'd4
    } sum_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } state_e;

    typedef struct packed {
        lane_mode_e lane;
        logic       bitrev;
        sum_kind_e  kind;
    } func_t;

    function automatic func_t decode_func(input logic [1:0] lane_f, input logic rev_f,
                                          input logic [1:0] en_f, input logic [2:0] kind_f);
        func_t f;
        f.lane   = lane_mode_e'(lane_f);
        f.bitrev = rev_f;
        f.kind   = SUM_OFF;
        if (en_f == 2'b11) begin
            case (kind_f)
                3'd1:    f.kind = SUM_CRC16;
                3'd2:    f.kind = SUM_CCITT;
                3'd3:    f.kind = SUM_CRC32;
                3'd4:    f.kind = SUM_INET;
                default: f.kind = SUM_OFF;
            endcase
        end
        return f;
    endfunction

    function automatic logic [31:0] crc32_step(input logic [31:0] acc, input logic [31:0] w);
        logic [31:0] c;
        c = acc;
        for (int i = 31; i >= 0; i--) begin
            if (c[31] ^ w[i]) c = (c << 1) ^ CRC32_POLY;
            else              c = c << 1;
        end
        return c;
    endfunction

    function automatic logic [15:0] crc16_step(input logic [15:0] acc, input logic [31:0] w,
                                               input logic [15:0] poly);
        logic [15:0] c;
        c = acc;
        for (int i = 31; i >= 0; i--) begin
            if (c[15] ^ w[i]) c = (c << 1) ^ poly;
            else              c = c << 1;
        end
        return c;
    endfunction

    function automatic logic [15:0] inet_step(input logic [15:0] acc, input logic [31:0] w);
        logic [17:0] s;
        logic [16:0] f;
        s = {2'b00, acc} + {2'b00, w[31:16]} + {2'b00, w[15:0]};
        f = {1'b0, s[15:0]} + {15'd0, s[17:16]};
        return f[15:0] + {15'd0, f[16]};
    endfunction

    function automatic logic [SUM_W-1:0] sum_seed(input sum_kind_e kind);
        case (kind)
            SUM_CCITT: return 32'h0000_FFFF;
            SUM_CRC32: return 32'hFFFF_FFFF;
            default:   return 32'h0000_0000;
        endcase
    endfunction

    function automatic logic [SUM_W-1:0] sum_next(input sum_kind_e kind,
                                                  input logic [SUM_W-1:0] acc,
                                                  input logic [31:0] w);
        case (kind)
            SUM_CRC16: return {16'd0, crc16_step(acc[15:0], w, CRC16_POLY)};
            SUM_CCITT: return {16'd0, crc16_step(acc[15:0], w, CCITT_POLY)};
            SUM_CRC32: return crc32_step(acc, w);
            SUM_INET:  return {16'd0, inet_step(acc[15:0], w)};
            default:   return acc;
        endcase
    endfunction

endpackage

// File: rtl/lane_permuter.sv
module lane_permuter
    import wrs_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int WORD_W = LANES * BYTE_W,
    localparam int SEL_W  = $clog2(LANES)
) (
    input  lane_mode_e        mode,
    input  logic              bitrev,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);

    logic [BYTE_W-1:0] lane_in [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [SEL_W-1:0]  src;
        logic [BYTE_W-1:0] picked;

        assign lane_in[k] = din[k*BYTE_W +: BYTE_W];

        always_comb begin
            case (mode)
                LANE_KEEP:     src = SEL_W'(k);
                LANE_FULLREV:  src = SEL_W'(LANES - 1 - k);
                LANE_HALFSWAP: src = SEL_W'(k) ^ SEL_W'(LANES / 2);
                LANE_HALFBYTE: src = SEL_W'(k) ^ SEL_W'(1);
                default:       src = SEL_W'(k);
            endcase
        end

        assign picked = lane_in[src];

        for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
            assign dout[k*BYTE_W + b] = bitrev ? picked[BYTE_W-1-b] : picked[b];
        end
    end

endmodule

// File: rtl/sum_accum.sv
module sum_accum
    import wrs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             open,
    input  logic             restart,
    input  sum_kind_e        kind,
    input  logic [31:0]      word,
    output logic [SUM_W-1:0] acc_q
);

    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] acc_d;

    always_comb begin
        base  = (open && restart) ? sum_seed(kind) : acc_q;
        acc_d = accept ? sum_next(kind, base, word) : acc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R5: without an accepted word the sum never moves
    assert_sum_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(acc_q));

    // R3: 16-bit kinds leave the upper half clear
    assert_sum_narrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (kind == SUM_CRC16 || kind == SUM_CCITT || kind == SUM_INET))
        |=> (acc_q[31:16] == 16'd0));

endmodule

// File: rtl/stage_ctrl.sv
module stage_ctrl
    import wrs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept,
    input  logic        in_last,
    input  logic [1:0]  lane_f,
    input  logic        rev_f,
    input  logic [1:0]  en_f,
    input  logic [2:0]  kind_f,
    input  logic        restart_in,
    output func_t       func_eff,
    output logic        restart_eff,
    output logic        open
);

    state_e state_q, state_d;
    func_t  func_q;
    func_t  func_cfg;

    assign func_cfg = decode_func(lane_f, rev_f, en_f, kind_f);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && !in_last) state_d = ST_BUSY;   // open
            ST_BUSY: if (accept && in_last)  state_d = ST_IDLE;   // close
            default: state_d = ST_IDLE;
        endcase
    end

    // state register, function latch on the opening word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            func_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && accept) func_q <= func_cfg;
        end
    end

    // outputs
    always_comb begin
        open        = 1'b0;
        func_eff    = func_q;
        restart_eff = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                open        = 1'b1;
                func_eff    = func_cfg;
                restart_eff = restart_in;
            end
            ST_BUSY: begin
                open        = 1'b0;
                func_eff    = func_q;
                restart_eff = 1'b0;
            end
            default: ;
        endcase
    end

    // R9: the latched function cannot change while a transfer is open
    assert_func_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |=> $stable(func_q));

    // R9: a word carrying the last flag always leaves the stage idle
    assert_close_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_last) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/word_reshape_sum.sv
module word_reshape_sum
    import wrs_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int WORD_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_func,
    input  logic              cfg_restart,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last,
    output logic [SUM_W-1:0]  csum_out
);

    logic              accept;
    logic              open;
    logic              restart_eff;
    func_t             func_eff;
    logic [WORD_W-1:0] shaped;
    logic              unused_cfg;

    assign unused_cfg = ^{cfg_func[29:23], cfg_func[18], cfg_func[15:0]};

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    stage_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .in_last     (in_last),
        .lane_f      (cfg_func[17:16]),
        .rev_f       (cfg_func[19]),
        .en_f        (cfg_func[31:30]),
        .kind_f      (cfg_func[22:20]),
        .restart_in  (cfg_restart),
        .func_eff    (func_eff),
        .restart_eff (restart_eff),
        .open        (open)
    );

    lane_permuter #(.LANES(LANES), .BYTE_W(BYTE_W)) u_perm (
        .mode   (func_eff.lane),
        .bitrev (func_eff.bitrev),
        .din    (in_data),
        .dout   (shaped)
    );

    sum_accum u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .open    (open),
        .restart (restart_eff),
        .kind    (func_eff.kind),
        .word    (shaped),
        .acc_q   (csum_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= shaped;
                out_last <= in_last;
            end
        end
    end

    // R8: a stalled word is held unchanged
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R8: an accepted word is presented on the next cycle
    assert_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

endmodule

// File: tb/word_reshape_sum_bench.sv
`timescale 1ns/1ps
module word_reshape_sum_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cfg_func;
    logic        cfg_restart;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_data;
    logic        in_last;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_data;
    logic        out_last;
    logic [31:0] csum_out;

    always #4 clk = ~clk;

    word_reshape_sum u_word_reshape_sum (
        .clk(clk), .rst_n(rst_n), .cfg_func(cfg_func), .cfg_restart(cfg_restart),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .csum_out(csum_out)
    );

    int total = 0;
    int bad   = 0;
    int bp_pct = 0;
    int gap_max = 0;

    logic [32:0] expq [$];
    bit          m_busy = 0;
    logic [1:0]  m_lane;
    bit          m_rev;
    int          m_kind;
    bit          m_restart;
    logic [31:0] m_acc = 32'd0;
    bit          sum_pend = 0;

    function automatic logic [31:0] b_shape(logic [31:0] w, logic [1:0] lane, bit rev);
        logic [31:0] t, r;
        case (lane)
            2'd0: t = w;
            2'd3: t = {w[7:0], w[15:8], w[23:16], w[31:24]};
            2'd2: t = {w[15:0], w[31:16]};
            default: t = {w[23:16], w[31:24], w[7:0], w[15:8]};
        endcase
        r = t;
        if (rev) for (int i = 0; i < 32; i++) r[i] = t[(i / 8) * 8 + 7 - (i % 8)];
        return r;
    endfunction

    function automatic int b_kind(logic [31:0] f);
        int k;
        if (f[31:30] != 2'b11) return 0;
        k = int'(f[22:20]);
        return (k >= 1 && k <= 4) ? k : 0;
    endfunction

    function automatic logic [31:0] b_seed(int kind);
        if (kind == 2) return 32'h0000FFFF;
        if (kind == 3) return 32'hFFFFFFFF;
        return 32'd0;
    endfunction

    function automatic logic [31:0] b_next(int kind, logic [31:0] acc, logic [31:0] w);
        logic [31:0] c;
        logic [7:0]  by;
        int unsigned s;
        int          width;
        logic [31:0] poly;
        if (kind == 0) return acc;
        if (kind == 4) begin
            s = int'(acc[15:0]) + int'(w[31:16]) + int'(w[15:0]);
            while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
            return s;
        end
        width = (kind == 3) ? 32 : 16;
        poly  = (kind == 3) ? 32'h04C11DB7 : ((kind == 1) ? 32'h8005 : 32'h1021);
        c = (width == 32) ? acc : {16'd0, acc[15:0]};
        for (int bidx = 3; bidx >= 0; bidx--) begin
            by = w[bidx*8 +: 8];
            for (int j = 7; j >= 0; j--) begin
                if (c[width-1] ^ by[j]) c = (c << 1) ^ poly;
                else                    c = c << 1;
                if (width == 16) c[31:16] = 16'd0;
            end
        end
        return c;
    endfunction

    function automatic logic [31:0] mkfunc(int lane, bit rev, int kind);
        logic [15:0] dig;
        logic [31:0] f;
        case (lane)
            0: dig = 16'h4567;
            3: dig = 16'h7654;
            2: dig = 16'h6745;
            default: dig = 16'h5476;
        endcase
        if (rev) dig = dig | 16'h8888;
        f = (kind == 0) ? 32'hA0000000 : (32'hC0000000 | (32'(kind) << 20));
        return f | {12'd0, dig, 4'd0};
    endfunction

    task automatic chk(string tag, logic [32:0] act, logic [32:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(output bit took);
        logic [32:0] e;
        logic [31:0] sh;
        out_ready = ($urandom_range(99) >= bp_pct);
        #1;
        took = 0;
        chk("R8 ready rule", {32'd0, in_ready}, {32'd0, (!out_valid || out_ready)});
        if (out_valid && out_ready) begin
            if (expq.size() == 0) chk("R8 extra output", {out_last, out_data}, 33'h1_FFFF_FFFF ^ {out_last, out_data});
            else begin
                e = expq.pop_front();
                chk("R1 R2 R8 R9 output word", {out_last, out_data}, e);
            end
        end
        if (in_valid && in_ready) begin
            if (!m_busy) begin
                m_lane    = cfg_func[17:16];
                m_rev     = cfg_func[19];
                m_kind    = b_kind(cfg_func);
                m_restart = cfg_restart;
                if (cfg_restart) m_acc = b_seed(m_kind);
            end
            sh = b_shape(in_data, m_lane, m_rev);
            expq.push_back({in_last, sh});
            m_acc  = b_next(m_kind, m_acc, sh);
            m_busy = !in_last;
            if (in_last) sum_pend = 1;
            took = 1;
        end
        @(negedge clk);
        if (sum_pend) begin
            sum_pend = 0;
            chk($sformatf("%s R11 %s checksum kind=%0d",
                 (m_kind == 0) ? "R5" : ((m_kind == 4) ? "R4" : "R3"),
                 m_restart ? "R6" : "R7", m_kind), {1'b0, csum_out}, {1'b0, m_acc});
        end
    endtask

    task automatic send_word(logic [31:0] d, bit last);
        bit a;
        in_data  = d;
        in_last  = last;
        in_valid = 1'b1;
        do tick(a); while (!a);
        in_valid = 1'b0;
        repeat ($urandom_range(gap_max)) tick(a);
    endtask

    task automatic transfer(logic [31:0] f, bit rs, int len, bit scramble);
        cfg_func    = f;
        cfg_restart = rs;
        for (int i = 0; i < len; i++) begin
            send_word($urandom, i == len - 1);
            if (i == 0 && scramble && len > 1) begin
                cfg_func    = $urandom;
                cfg_restart = $urandom_range(1);
            end
        end
    endtask

    task automatic direct_shape(int lane, bit rev, logic [31:0] d, logic [31:0] exp, string tag);
        cfg_func    = mkfunc(lane, rev, 3);
        cfg_restart = 1'b1;
        bp_pct  = 0;
        gap_max = 0;
        in_data  = d;
        in_last  = 1'b1;
        in_valid = 1'b1;
        begin
            bit a;
            do tick(a); while (!a);
        end
        in_valid = 1'b0;
        chk(tag, {out_valid, out_data}, {1'b1, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit a;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        cfg_func = mkfunc(0, 0, 0);
        cfg_restart = 1'b0;
        in_valid = 1'b0;
        in_data = 32'd0;
        in_last = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 reset out_valid", {32'd0, out_valid}, 33'd0);
        chk("R10 reset in_ready", {32'd0, in_ready}, 33'd1);
        chk("R10 reset csum_out", {1'b0, csum_out}, 33'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after reset csum_out", {1'b0, csum_out}, 33'd0);

        // directed lane orders and bit reversal
        direct_shape(0, 0, 32'h11223344, 32'h11223344, "R1 keep");
        direct_shape(3, 0, 32'h11223344, 32'h44332211, "R1 full reverse");
        direct_shape(2, 0, 32'h11223344, 32'h33441122, "R1 half swap");
        direct_shape(1, 0, 32'h11223344, 32'h22114433, "R1 byte-in-half swap");
        direct_shape(0, 1, 32'h01800F00, 32'h8001F000, "R2 bit reverse");
        direct_shape(3, 1, 32'h01800F00, 32'h00F00180, "R2 reverse after lanes");

        // restart versus continuation, disabled sum, each kind
        for (int k = 1; k <= 4; k++) begin
            transfer(mkfunc(0, 0, k), 1'b1, 3, 1'b0);
            transfer(mkfunc(2, 1, k), 1'b0, 2, 1'b0);
        end
        transfer(mkfunc(1, 0, 0), 1'b0, 4, 1'b0);
        transfer(mkfunc(1, 0, 0), 1'b1, 2, 1'b0);

        // heavy backpressure with a mid-transfer change of the function word
        bp_pct = 90;
        transfer(mkfunc(3, 1, 3), 1'b1, 20, 1'b1);

        // random mix
        for (int n = 0; n < 250; n++) begin
            bp_pct  = $urandom_range(60);
            gap_max = $urandom_range(2);
            transfer(mkfunc($urandom_range(3), 1'($urandom_range(1)), $urandom_range(4)),
                     ($urandom_range(3) != 0), $urandom_range(1, 12), 1'($urandom_range(1)));
        end

        bp_pct = 0;
        in_valid = 1'b0;
        while (expq.size() > 0) tick(a);
        repeat (2) tick(a);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule